// File: doc/BRIEF.md
# Prioritizing Interrupt Controller with Reorderable Groups

The controller gathers interrupt requests from a parameterized set of sources, keeps a pending bit for each, and turns the pending and enabled ones into three request lines toward a processor core: normal, critical and system-management. A fourth line, machine check, is raised from a dedicated error input or an external machine-check request. Each source is routed to one of the three maskable classes by a two-bit class field. For each class the block keeps a vector register that reports which eligible source has the highest priority.

Priority is fixed by source number, with a lower number winning. The exception is one contiguous group of sources, whose order software sets through slot fields in an order register. Slot k decides which group member sits at the k-th position of the group. If a group member is not named by any slot, it ranks below every other source. Edge sources latch until software clears them. Level sources follow their input. A simple read/write port reaches the enables, the class routing, the group order, the pending bits and the three vectors. Reading a vector register holds its value steady for as long as the read strobe stays high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `irq_mchk_o` is high exactly one cycle after a cycle in which `err_i` or `mcp_req_i` was high, and low one cycle after both were low.
- R2: A class request output is high only when at least one source is pending, enabled (its bit in the enable register at address 1 is 1) and routed to that class. It rises two cycles after an edge-source pulse and one cycle after the enabling write.
- R3: A source's pending bit is set when the source fires, even when its enable bit is 0. The bit reads back at address 0, bit i for source i.
- R4: A vector register holds source index + 1 of the winning eligible source of its class, and holds 0 when no eligible source of that class is pending. It updates on the same cycle as the class request.
- R5: Outside the group, among eligible sources of one class, the lower source index wins.
- R6: While `reg_rd_i` is held high with `reg_addr_i` at a vector address, that vector register does not change, even if a higher-priority source becomes pending. It resumes tracking one cycle after the strobe drops.
- R7: The order register at address 3 has a 2-bit field per group slot at bits [2k+1:2k]. Slot 0 has the highest priority in the group, and its field gives the member offset from the group base (source 4 by default). The register resets to 0xE4 (identity order).
- R8: Vector registers sit at address 4 (normal), 5 (critical) and 6 (system management). Read data carries the vector in bits [6:0] and zero in bits [31:7].
- R9: The class register at address 2 holds 2 bits per source at bits [2i+1:2i]. Code 0 means normal, 1 critical, 2 system management, and 3 also routes to normal.
- R10: An edge source's pending bit (sources 0 to 7 by default) stays set until a write to address 0 with a 1 in that bit position. If a new edge arrives in the same cycle as the clear, the edge wins.
- R11: A level source's pending bit (sources 8 to 15 by default) equals the input one cycle earlier. Writes to address 0 have no effect on it.
- R12: After reset, all request outputs, enables, class fields, pending bits and vectors are 0, and the order register reads 0xE4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_irq_i | input | NUM_SRC | Interrupt source inputs |
| err_i | input | 1 | Internal error condition for machine check |
| mcp_req_i | input | 1 | External machine-check request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (freezes an addressed vector) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational from registered state) |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |
| irq_smi_o | output | 1 | System-management interrupt request |
| irq_mchk_o | output | 1 | Machine-check request |

## Verification
An edge on a source reaches its pending bit after one rising edge, and the class request and vector after a second. A write to the enable, class or order register moves the request and vector after one edge. The machine-check line follows its inputs after one edge. Each scenario drives inputs on the falling edge and then waits exactly that many falling edges before sampling. Reads are made just after a falling edge and released before the next rising edge, so they never freeze a vector unless a test holds the strobe on purpose.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int VEC_W     = 7;
    localparam int NUM_CLASS = 3;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_CRIT = 2'd1,
        CLS_SMI  = 2'd2,
        CLS_ALT  = 2'd3
    } irq_class_e;

    localparam logic [3:0] A_PEND  = 4'd0;
    localparam logic [3:0] A_ENAB  = 4'd1;
    localparam logic [3:0] A_CLASS = 4'd2;
    localparam logic [3:0] A_ORDER = 4'd3;
    localparam logic [3:0] A_VEC_N = 4'd4;
    localparam logic [3:0] A_VEC_C = 4'd5;
    localparam logic [3:0] A_VEC_S = 4'd6;
endpackage

// File: rtl/ipc_pending.sv
module ipc_pending #(
    parameter int               NUM_SRC   = 16,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] pend;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d.prev = src_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (EDGE_MASK[i]) begin
                st_d.pend[i] = (st_q.pend[i] & ~clr_i[i]) | (src_i[i] & ~st_q.prev[i]);
            end else begin
                st_d.pend[i] = src_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    logic unused_lvl;
    assign unused_lvl = ^(clr_i & ~EDGE_MASK) ^ ^(st_q.prev & ~EDGE_MASK);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        if (EDGE_MASK[i]) begin : g_edge
            // R10: a latched edge survives until an explicit clear
            p_edge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(pend_o[i]) && !$past(clr_i[i])) |-> pend_o[i]);
        end else begin : g_lvl
            // R11: level pending follows the input one cycle later
            p_level_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (pend_o[i] == $past(src_i[i])));
        end
    end
endmodule

// File: rtl/ipc_resolver.sv
module ipc_resolver
    import ipc_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int GRP_BASE = 4,
    parameter int GRP_SIZE = 4,
    parameter int GW       = 2
) (
    input  logic [NUM_SRC-1:0]     eligible_i,
    input  logic [GRP_SIZE*GW-1:0] order_i,
    output logic                   found_o,
    output logic [VEC_W-1:0]       vec_o
);
    localparam int N_ENT = NUM_SRC + GRP_SIZE;

    logic [GRP_SIZE-1:0] named;

    always_comb begin
        int  s;
        int  m;
        logic ok;
        named = '0;
        for (int k = 0; k < GRP_SIZE; k++) begin
            named[order_i[k*GW +: GW]] = 1'b1;
        end
        found_o = 1'b0;
        vec_o   = '0;
        s  = 0;
        m  = 0;
        ok = 1'b0;
        // scan from lowest priority upward so the best entry is written last
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (e >= NUM_SRC) begin
                m  = e - NUM_SRC;
                s  = GRP_BASE + m;
                ok = !named[m];
            end else if (e >= GRP_BASE && e < GRP_BASE + GRP_SIZE) begin
                s  = GRP_BASE + int'(order_i[(e - GRP_BASE)*GW +: GW]);
                ok = 1'b1;
            end else begin
                s  = e;
                ok = 1'b1;
            end
            if (ok && eligible_i[s]) begin
                found_o = 1'b1;
                vec_o   = VEC_W'(s + 1);
            end
        end
        // R4: a winner exists exactly when some source is eligible
        a_found_r4: assert (found_o == (|eligible_i));
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int                 NUM_SRC   = 16,
    parameter int                 GRP_BASE  = 4,
    parameter int                 GRP_SIZE  = 4,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 16'h00FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq_i,
    input  logic               err_i,
    input  logic               mcp_req_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [3:0]         reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_norm_o,
    output logic               irq_crit_o,
    output logic               irq_smi_o,
    output logic               irq_mchk_o
);
    localparam int GW    = (GRP_SIZE > 1) ? $clog2(GRP_SIZE) : 1;
    localparam int ORD_W = GRP_SIZE * GW;
    localparam int CLS_W = 2 * NUM_SRC;

    typedef struct packed {
        logic [NUM_SRC-1:0]                  en;
        logic [CLS_W-1:0]                    cls;
        logic [ORD_W-1:0]                    ord;
        logic [NUM_CLASS-1:0][VEC_W-1:0]     vec;
        logic [NUM_CLASS-1:0]                req;
        logic                                mchk;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC-1:0]                  pend_q;
    logic [NUM_SRC-1:0]                  clr;
    logic [NUM_CLASS-1:0][NUM_SRC-1:0]   elig;
    logic [NUM_CLASS-1:0]                found;
    logic [NUM_CLASS-1:0][VEC_W-1:0]     res_vec;
    logic [NUM_CLASS-1:0]                freeze;

    function automatic logic [ORD_W-1:0] ident_order();
        logic [ORD_W-1:0] r;
        r = '0;
        for (int k = 0; k < GRP_SIZE; k++) r[k*GW +: GW] = GW'(k);
        return r;
    endfunction

    assign clr = (reg_wr_i && reg_addr_i == A_PEND) ? reg_wdata_i[NUM_SRC-1:0] : '0;

    ipc_pending #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_irq_i),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    always_comb begin
        logic [1:0] code;
        for (int c = 0; c < NUM_CLASS; c++) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                code = st_q.cls[2*i +: 2];
                if (code == CLS_ALT) code = CLS_NORM;
                elig[c][i] = pend_q[i] & st_q.en[i] & (code == 2'(c));
            end
            freeze[c] = reg_rd_i && (reg_addr_i == A_VEC_N + 4'(c));
        end
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        ipc_resolver #(
            .NUM_SRC (NUM_SRC),
            .GRP_BASE(GRP_BASE),
            .GRP_SIZE(GRP_SIZE),
            .GW      (GW)
        ) u_res (
            .eligible_i(elig[c]),
            .order_i   (st_q.ord),
            .found_o   (found[c]),
            .vec_o     (res_vec[c])
        );
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_ENAB:  st_d.en  = reg_wdata_i[NUM_SRC-1:0];
                A_CLASS: st_d.cls = reg_wdata_i[CLS_W-1:0];
                A_ORDER: st_d.ord = reg_wdata_i[ORD_W-1:0];
                default: ;
            endcase
        end
        for (int c = 0; c < NUM_CLASS; c++) begin
            st_d.req[c] = found[c];
            if (!freeze[c]) st_d.vec[c] = res_vec[c];
        end
        st_d.mchk = err_i | mcp_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ord <= ident_order();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_PEND:  reg_rdata_o = 32'(pend_q);
            A_ENAB:  reg_rdata_o = 32'(st_q.en);
            A_CLASS: reg_rdata_o = 32'(st_q.cls);
            A_ORDER: reg_rdata_o = 32'(st_q.ord);
            A_VEC_N: reg_rdata_o = 32'(st_q.vec[0]);
            A_VEC_C: reg_rdata_o = 32'(st_q.vec[1]);
            A_VEC_S: reg_rdata_o = 32'(st_q.vec[2]);
            default: reg_rdata_o = '0;
        endcase
    end

    assign irq_norm_o = st_q.req[0];
    assign irq_crit_o = st_q.req[1];
    assign irq_smi_o  = st_q.req[2];
    assign irq_mchk_o = st_q.mchk;

    // R1: either machine-check cause raises the line on the next cycle
    p_mchk_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i || mcp_req_i) |=> irq_mchk_o);

    // R2: a normal request needs some pending and enabled source behind it
    p_req_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm_o |-> $past(|(pend_q & st_q.en)));

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_vchk
        // R6: a vector under read does not move
        p_vec_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(freeze[c]) |-> $stable(st_q.vec[c]));
        // R4: a vector never names a source beyond the last one
        p_vec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.vec[c] <= VEC_W'(NUM_SRC));
    end
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    import ipc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          err = 1'b0;
    logic          mcp = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_n, irq_c, irq_s, irq_m;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_irq_i  (src),
        .err_i      (err),
        .mcp_req_i  (mcp),
        .reg_wr_i   (reg_wr),
        .reg_rd_i   (reg_rd),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_norm_o (irq_n),
        .irq_crit_o (irq_c),
        .irq_smi_o  (irq_s),
        .irq_mchk_o (irq_m)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        reg_rd   = 1'b0;
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        src = src | m;
        @(negedge clk);
        src = src & ~m;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R12 irq outputs", {28'd0, irq_n, irq_c, irq_s, irq_m}, 32'd0);
        rd(A_ENAB, v);  chk("R12 enable", v, 32'd0);
        rd(A_ORDER, v); chk("R12 order", v, 32'hE4);
        rd(A_VEC_N, v); chk("R12 vec normal", v, 32'd0);
        rd(A_PEND, v);  chk("R12 pending", v, 32'd0);
    endtask

    task automatic t_masked_pending();
        logic [31:0] v;
        pulse(16'h0004);
        wait_cyc(2);
        rd(A_PEND, v);  chk("R3 pending while masked", v & 32'h4, 32'h4);
        chk("R2 masked no request", {31'd0, irq_n}, 32'd0);
        rd(A_VEC_N, v); chk("R4 no eligible vec 0", v, 32'd0);
    endtask

    task automatic t_enable_clear();
        logic [31:0] v;
        wr(A_ENAB, 32'h4);
        wait_cyc(1);
        chk("R2 request after enable", {31'd0, irq_n}, 32'd1);
        rd(A_VEC_N, v); chk("R4 vec source 2", v, 32'd3);
        wr(A_PEND, 32'h4);
        wait_cyc(1);
        chk("R10 request gone after clear", {31'd0, irq_n}, 32'd0);
        rd(A_VEC_N, v); chk("R4 vec back to 0", v, 32'd0);
        rd(A_PEND, v);  chk("R10 pending cleared", v & 32'h4, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(A_ENAB, 32'h200);
        src[9] = 1'b1;
        wait_cyc(2);
        rd(A_PEND, v);  chk("R11 level pending set", v & 32'h200, 32'h200);
        chk("R2 level request", {31'd0, irq_n}, 32'd1);
        rd(A_VEC_N, v); chk("R4 vec source 9", v, 32'd10);
        wr(A_PEND, 32'h200);
        rd(A_PEND, v);  chk("R11 clear write ignored", v & 32'h200, 32'h200);
        src[9] = 1'b0;
        wait_cyc(1);
        rd(A_PEND, v);  chk("R11 level pending follows low", v & 32'h200, 32'd0);
        wait_cyc(1);
        chk("R2 level request dropped", {31'd0, irq_n}, 32'd0);
    endtask

    task automatic t_priority_class();
        logic [31:0] v;
        wr(A_ENAB, 32'hFFFF);
        src[10] = 1'b1;
        pulse(16'h000A);
        wait_cyc(1);
        rd(A_VEC_N, v); chk("R5 lowest index wins", v, 32'd2);
        wr(A_CLASS, (32'd1 << 20) | (32'd2 << 6) | (32'd3 << 2));
        wait_cyc(1);
        chk("R9 critical line", {31'd0, irq_c}, 32'd1);
        chk("R9 smi line", {31'd0, irq_s}, 32'd1);
        rd(A_VEC_C, v); chk("R9 critical vec", v, 32'd11);
        rd(A_VEC_S, v); chk("R9 smi vec", v, 32'd4);
        rd(A_VEC_N, v); chk("R9 code 3 routes normal", v, 32'd2);
        src[12] = 1'b1;
        wr(A_CLASS, (32'd2 << 24) | (32'd1 << 20) | (32'd2 << 6) | (32'd3 << 2));
        wait_cyc(1);
        rd(A_VEC_S, v); chk("R5 smi highest kept", v, 32'd4);
        src[10] = 1'b0;
        src[12] = 1'b0;
        wr(A_PEND, 32'h000A);
        wr(A_CLASS, 32'd0);
        wait_cyc(1);
        chk("R2 all quiet", {29'd0, irq_n, irq_c, irq_s}, 32'd0);
    endtask

    task automatic t_group();
        logic [31:0] v;
        pulse(16'h0060);
        wait_cyc(2);
        rd(A_VEC_N, v); chk("R7 identity order", v, 32'd6);
        wr(A_ORDER, 32'hD2);
        wait_cyc(1);
        rd(A_VEC_N, v); chk("R7 reordered winner", v, 32'd7);
        rd(A_ORDER, v); chk("R7 order readback", v, 32'hD2);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        reg_addr = A_VEC_N;
        reg_rd   = 1'b1;
        pulse(16'h0002);
        wait_cyc(3);
        chk("R6 vector frozen during read", reg_rdata, 32'd7);
        reg_rd = 1'b0;
        wait_cyc(1);
        rd(A_VEC_N, v); chk("R6 vector resumes", v, 32'd2);
        wr(A_PEND, 32'h0062);
        wr(A_ORDER, 32'hE4);
        wait_cyc(1);
    endtask

    task automatic t_mcheck();
        err = 1'b1;
        wait_cyc(1);
        chk("R1 error raises mcheck", {31'd0, irq_m}, 32'd1);
        err = 1'b0;
        wait_cyc(1);
        chk("R1 mcheck drops", {31'd0, irq_m}, 32'd0);
        mcp = 1'b1;
        wait_cyc(1);
        chk("R1 external request raises mcheck", {31'd0, irq_m}, 32'd1);
        mcp = 1'b0;
        wait_cyc(1);
        chk("R1 mcheck drops again", {31'd0, irq_m}, 32'd0);
    endtask

    task automatic t_upper();
        logic [31:0] v;
        src[15] = 1'b1;
        wait_cyc(2);
        rd(A_VEC_N, v); chk("R8 full vector word", v, 32'd16);
        src[15] = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_masked_pending();
        t_enable_clear();
        t_level();
        t_priority_class();
        t_group();
        t_freeze();
        t_mcheck();
        t_upper();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule